// File: doc/BRIEF.md
# DRAM Cycle Decoder with Refresh Row Counter

This block is a synthesizable, device-side model of an asynchronous multiplexed-address DRAM, intended as a target for memory-controller verification. It oversamples the active-low row strobe, column strobe, write enable and output enable, together with the shared address pins and the data-in bus, on a fast system clock. From the order of the strobe edges and the write-enable level, it decides which kind of cycle the controller is running. The supported cycles are read, early write, read-modify-write, row-strobe-only refresh, column-before-row refresh and hidden refresh.

The row is captured when the row strobe falls and the column when the column strobe falls. Write data is taken at the write point. A 9-bit refresh row counter supplies the row for the two refresh cycles that take no address. The stored contents live in a small array that keeps only the low bits of row and column, so higher address bits alias.

Every completed cycle is reported once on an event bus: a strobe, a 3-bit kind code and the row concerned. Read data is presented on a registered output with its own enable. Analog retention and access-delay timing are not modelled.

Top module: `dram_cycle_decoder`

## Requirements
- R1: The row is taken from `addr` at the row-strobe fall and the column at the column-strobe fall. The array is indexed by the low ROW_KEEP bits of the row and the low COL_KEEP bits of the column, so row 21, column 19 aliases row 5, column 3 with the defaults of 4 and 4.
- R2: When `we_n` is low at the column-strobe fall, the cycle is an early write. `din` is stored at that fall. `dout_en` stays 0 until the column strobe rises, whatever `oe_n` does. At the column-strobe rise, event code 2 is reported.
- R3: When `we_n` is high at the column-strobe fall and stays high, the cycle is a read. The addressed data appears on `dout`, and `dout_en` is 1 while the column strobe is low and `oe_n` is low. At the column-strobe rise, event code 1 is reported.
- R4: When `we_n` falls after the column strobe has fallen in a read, the cycle is a read-modify-write. The earlier contents are read out first, and `din` is stored at the `we_n` fall. At the column-strobe rise, event code 3 is reported.
- R5: When the row strobe falls and rises while the column strobe stays high, the cycle is a row-only refresh. Event code 4 is reported at the row-strobe rise, with `evt_row` equal to the address at the row-strobe fall. `we_n`, `oe_n` and `din` change nothing in the array.
- R6: When the column strobe is already low at the row-strobe fall and no read is being held, the cycle is a column-before-row refresh. Event code 5 is reported at the row-strobe fall, with `evt_row` equal to the refresh counter, and the counter then advances. The address pins, `we_n` and `din` are ignored.
- R7: When the column strobe is held low after a read and the row strobe falls again, the cycle is a hidden refresh. Event code 6 is reported with the counter row, and the counter advances. The read data stays driven on `dout` with `dout_en` at 1 until the column strobe rises, and the read event follows at that rise.
- R8: The refresh counter is 0 after reset, steps by one per code 5 or code 6 event, and wraps from 511 to 0.
- R9: When the column strobe falls and then rises again while the row strobe stays high, `viol` pulses for one clock and no event is reported.
- R10: After reset, `evt_valid`, `dout_en` and `viol` are 0. Each event strobe lasts one clock and is first seen two clocks after the pin edge that causes it is applied.
- R11: Several column-strobe cycles within one row-strobe low period each give their own event, and all of them carry the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the DRAM pins |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data (registered) |
| dout_en | output | 1 | Read data is being driven |
| evt_valid | output | 1 | One-clock event strobe |
| evt_code | output | 3 | Cycle kind: 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh |
| evt_row | output | ADDR_W | Row accessed or refreshed |
| viol | output | 1 | Column strobe cycled with no row strobe |

## Verification
The functions that overlap in time are the hidden refresh and the held read. In the same clock, the counter advances and the refresh event fires while the read data must still be driven. The bench provokes this by completing a read, raising the row strobe with the column strobe still low, and dropping the row strobe again. A behavioural reference model checks, on every clock, that `dout_en` and `dout` keep the read value across the refresh event. It also checks that the read event follows at the later column-strobe rise, with the counter row and then the read row reported in that order.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_READ   = 3'd1,
    EV_EWRITE = 3'd2,
    EV_RMW    = 3'd3,
    EV_RONLY  = 3'd4,
    EV_CBR    = 3'd5,
    EV_HIDDEN = 3'd6
  } ev_code_t;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACCESS  = 2'd1,
    PH_REFRESH = 2'd2
  } phase_t;

endpackage

// File: rtl/dcd_pin_sampler.sv
module dcd_pin_sampler #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              ras_s,
  output logic              cas_s,
  output logic              we_s,
  output logic              oe_s,
  output logic [ADDR_W-1:0] addr_s,
  output logic [DATA_W-1:0] din_s,
  output logic              ras_fall,
  output logic              ras_rise,
  output logic              cas_fall,
  output logic              cas_rise,
  output logic              we_fall
);

  localparam int NSTROBE = 3;

  logic [NSTROBE-1:0] pin_vec;
  logic [NSTROBE-1:0] cur_q;
  logic [NSTROBE-1:0] old_q;

  assign pin_vec = {we_n, cas_n, ras_n};

  // one capture and one history flop per strobe, idle level is high
  for (genvar g = 0; g < NSTROBE; g++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) begin
        cur_q[g] <= 1'b1;
        old_q[g] <= 1'b1;
      end else begin
        cur_q[g] <= pin_vec[g];
        old_q[g] <= cur_q[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_s   <= 1'b1;
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      oe_s   <= oe_n;
      addr_s <= addr;
      din_s  <= din;
    end
  end

  assign ras_s    = cur_q[0];
  assign cas_s    = cur_q[1];
  assign we_s     = cur_q[2];
  assign ras_fall = old_q[0] & ~cur_q[0];
  assign ras_rise = ~old_q[0] & cur_q[0];
  assign cas_fall = old_q[1] & ~cur_q[1];
  assign cas_rise = ~old_q[1] & cur_q[1];
  assign we_fall  = old_q[2] & ~cur_q[2];

endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] row
);

  always_ff @(posedge clk) begin
    if (rst)       row <= '0;
    else if (step) row <= row + 1'b1;
  end

  // R8: one step per refresh, wrapping at the width
  a_r8_ctr_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(step)) |-> (row == $past(row) + 1'b1));

  // R8: no drift without a refresh
  a_r8_ctr_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(step)) |-> $stable(row));

endmodule

// File: rtl/dcd_store.sv
module dcd_store #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // R4: a read and a write never share a cycle, even in read-modify-write
  a_r4_port_excl: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ADDR_W   = 9,
  parameter int DATA_W   = 4,
  parameter int ROW_KEEP = 4,
  parameter int COL_KEEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              evt_valid,
  output logic [2:0]        evt_code,
  output logic [ADDR_W-1:0] evt_row,
  output logic              viol
);
  import dcd_pkg::*;

  localparam int STORE_AW = ROW_KEEP + COL_KEEP;

  logic              ras_s, cas_s, we_s, oe_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              ras_fall, ras_rise, cas_fall, cas_rise, we_fall;

  dcd_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din),
    .ras_s(ras_s), .cas_s(cas_s), .we_s(we_s), .oe_s(oe_s),
    .addr_s(addr_s), .din_s(din_s),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall)
  );

  phase_t            phase;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              col_seen, rd_open, acc_pend, cbr_arm;
  ev_code_t          acc_code, ev_q;
  logic [ADDR_W-1:0] ref_row;

  logic ref_hit, acc_start, col_hit, ewr_hit, rd_hit, rmw_hit;
  logic ronly_hit, end_hit, viol_hit, rd_open_nx;
  logic              wr_en, rd_en;
  logic [STORE_AW-1:0] wr_addr, rd_addr;

  always_comb begin
    ref_hit    = ras_fall && !cas_s;
    acc_start  = ras_fall && cas_s;
    col_hit    = cas_fall && !ras_s && (phase == PH_ACCESS);
    ewr_hit    = col_hit && !we_s;
    rd_hit     = col_hit && we_s;
    rmw_hit    = we_fall && !cas_fall && !cas_s && acc_pend && (acc_code == EV_READ);
    ronly_hit  = ras_rise && (phase == PH_ACCESS) && !col_seen;
    end_hit    = cas_rise && acc_pend;
    viol_hit   = cas_rise && ras_s && cbr_arm;
    if (rd_hit)        rd_open_nx = 1'b1;
    else if (cas_rise) rd_open_nx = 1'b0;
    else               rd_open_nx = rd_open;
  end

  dcd_refresh_ctr #(.ROW_W(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .step(ref_hit), .row(ref_row)
  );

  assign wr_en   = ewr_hit || rmw_hit;
  assign rd_en   = rd_hit;
  assign rd_addr = {row_q[ROW_KEEP-1:0], addr_s[COL_KEEP-1:0]};
  assign wr_addr = ewr_hit ? {row_q[ROW_KEEP-1:0], addr_s[COL_KEEP-1:0]}
                           : {row_q[ROW_KEEP-1:0], col_q[COL_KEEP-1:0]};

  dcd_store #(.AW(STORE_AW), .DW(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(din_s),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      col_seen  <= 1'b0;
      rd_open   <= 1'b0;
      acc_pend  <= 1'b0;
      acc_code  <= EV_NONE;
      cbr_arm   <= 1'b0;
      evt_valid <= 1'b0;
      ev_q      <= EV_NONE;
      evt_row   <= '0;
      viol      <= 1'b0;
      dout_en   <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      ev_q      <= EV_NONE;
      viol      <= viol_hit;
      rd_open   <= rd_open_nx;
      dout_en   <= rd_open_nx && !oe_s;

      // row strobe side
      if (ref_hit) begin
        phase     <= PH_REFRESH;
        evt_valid <= 1'b1;
        ev_q      <= rd_open ? EV_HIDDEN : EV_CBR;
        evt_row   <= ref_row;
      end else if (acc_start) begin
        phase    <= PH_ACCESS;
        row_q    <= addr_s;
        col_seen <= 1'b0;
      end else if (ras_rise) begin
        phase <= PH_IDLE;
        if (ronly_hit) begin
          evt_valid <= 1'b1;
          ev_q      <= EV_RONLY;
          evt_row   <= row_q;
        end
      end

      // column strobe side
      if (col_hit) begin
        col_seen <= 1'b1;
        col_q    <= addr_s;
        acc_pend <= 1'b1;
        acc_code <= we_s ? EV_READ : EV_EWRITE;
      end else if (rmw_hit) begin
        acc_code <= EV_RMW;
      end else if (end_hit) begin
        acc_pend  <= 1'b0;
        evt_valid <= 1'b1;
        ev_q      <= acc_code;
        evt_row   <= row_q;
      end

      // column strobe cycled ahead of a row strobe
      if (cas_fall && ras_s)         cbr_arm <= 1'b1;
      else if (ras_fall || cas_rise) cbr_arm <= 1'b0;
    end
  end

  assign evt_code = ev_q;

  // R2: an early write never drives the outputs
  a_r2_ewrite_quiet: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_code == EV_EWRITE) |-> !dout_en);

  // R3: data is driven only while the column strobe was low
  a_r3_dout_cas_low: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> !$past(cas_s));

  // R9: the violation flag is a single-clock pulse
  a_r9_viol_pulse: assert property (@(posedge clk) disable iff (rst)
    viol |=> !viol);

  // R9: a violation is never reported as a cycle
  a_r9_viol_no_evt: assert property (@(posedge clk) disable iff (rst)
    viol |-> !evt_valid);

endmodule

// File: tb/dram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module dram_cycle_decoder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_en, evt_valid, viol;
  logic [2:0] evt_code;
  logic [8:0] evt_row;

  always #10 clk = ~clk;

  dram_cycle_decoder u_dram_cycle_decoder (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_row(evt_row), .viol(viol)
  );

  int checks = 0;
  int fails  = 0;
  int cnt_exp = 0;
  int viol_seen = 0;
  int q_code[$];
  int q_row[$];
  bit armed = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model, stepped on every rising edge -------------
  int  mem_m [int];
  bit  p_ras = 1, p_cas = 1, p_we = 1;
  int  m_phase = 0, m_row = 0, m_col = 0, m_cnt = 0, m_code = 0;
  bit  m_seen = 0, m_open = 0, m_pend = 0, m_arm = 0;
  bit  s_ev = 0, s_viol = 0, s_en = 0;
  int  s_code = 0, s_row = 0, s_dout = 0;
  bit  e_ev = 0, e_viol = 0, e_en = 0;
  int  e_code = 0, e_row = 0, e_dout = 0;

  function automatic int key(input int r, input int c);
    return ((r & 15) << 4) | (c & 15);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      p_ras = 1; p_cas = 1; p_we = 1;
      m_phase = 0; m_seen = 0; m_open = 0; m_pend = 0; m_arm = 0; m_cnt = 0;
      s_ev = 0; s_viol = 0; s_en = 0; e_ev = 0; e_viol = 0; e_en = 0;
    end else begin
      bit rf, rr, cf, cr, wf, hit_ref, hit_col, hit_rmw, hit_end, hit_ronly;
      bit open_new;
      e_ev = s_ev; e_code = s_code; e_row = s_row;
      e_viol = s_viol; e_en = s_en; e_dout = s_dout;
      rf = p_ras && !ras_n;  rr = !p_ras && ras_n;
      cf = p_cas && !cas_n;  cr = !p_cas && cas_n;
      wf = p_we && !we_n;
      hit_ref   = rf && !cas_n;
      hit_col   = cf && !ras_n && m_phase == 1;
      hit_rmw   = wf && !cf && !cas_n && m_pend && m_code == 1;
      hit_end   = cr && m_pend;
      hit_ronly = rr && m_phase == 1 && !m_seen;
      s_ev = 0;
      s_viol = cr && ras_n && m_arm;
      if (hit_ref) begin
        s_ev = 1; s_code = m_open ? 6 : 5; s_row = m_cnt;
      end
      if (hit_ronly) begin s_ev = 1; s_code = 4; s_row = m_row; end
      if (hit_end)   begin s_ev = 1; s_code = m_code; s_row = m_row; end
      if (hit_col && we_n) s_dout = mem_m.exists(key(m_row, addr)) ? mem_m[key(m_row, addr)] : 0;
      if (hit_col && !we_n) mem_m[key(m_row, addr)] = din;
      if (hit_rmw) mem_m[key(m_row, m_col)] = din;
      open_new = (hit_col && we_n) ? 1'b1 : (cr ? 1'b0 : m_open);
      s_en = open_new && !oe_n;
      // state update
      if (hit_ref) begin m_phase = 2; m_cnt = (m_cnt + 1) % 512; end
      else if (rf) begin m_phase = 1; m_row = addr; m_seen = 0; end
      else if (rr) m_phase = 0;
      if (hit_col) begin m_seen = 1; m_col = addr; m_pend = 1; m_code = we_n ? 1 : 2; end
      else if (hit_rmw) m_code = 3;
      else if (hit_end) m_pend = 0;
      if (cf && ras_n) m_arm = 1;
      else if (rf || cr) m_arm = 0;
      m_open = open_new;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end
  end

  // per-clock comparison and event capture, away from the rising edge
  always @(negedge clk) begin
    if (armed) begin
      chk("R10 evt_valid", evt_valid, e_ev);
      if (e_ev) begin
        chk("R3 evt_code", evt_code, e_code);
        chk("R5 evt_row", evt_row, e_row);
      end
      chk("R9 viol", viol, e_viol);
      chk("R3 dout_en", dout_en, e_en);
      if (e_en) chk("R1 dout", dout, e_dout);
    end
    if (!rst && evt_valid) begin
      q_code.push_back(evt_code);
      q_row.push_back(evt_row);
    end
    if (!rst && viol) viol_seen++;
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(input string tag, input int code, input int row);
    if (q_code.size() == 0) begin
      checks++; fails++;
      $display("FAIL %s act=none exp=%0d/%0h", tag, code, row);
    end else begin
      chk({tag, " code"}, q_code.pop_front(), code);
      chk({tag, " row"}, q_row.pop_front(), row);
    end
  endtask

  task automatic early_write(input int row, input int col, input int data);
    addr = 9'(row); ras_n = 0; step(2);
    addr = 9'(col); we_n = 0; din = 4'(data); oe_n = 0; cas_n = 0; step(3);
    chk("R2 outputs off in early write", dout_en, 0);
    cas_n = 1; we_n = 1; oe_n = 1; step(2);
    ras_n = 1; step(4);
    expect_ev("R2 early write event", 2, row);
  endtask

  task automatic open_read(input int row, input int col, input int exp, input string tag);
    addr = 9'(row); ras_n = 0; step(2);
    addr = 9'(col); oe_n = 0; cas_n = 0; step(3);
    chk({tag, " dout_en"}, dout_en, 1);
    chk({tag, " dout"}, dout, exp);
  endtask

  task automatic do_read(input int row, input int col, input int exp, input string tag);
    open_read(row, col, exp, tag);
    cas_n = 1; oe_n = 1; step(2);
    ras_n = 1; step(4);
    expect_ev("R3 read event", 1, row);
  endtask

  task automatic cbr_cycle(input string tag);
    addr = 9'h07; we_n = 0; din = 4'hF; cas_n = 0; step(2);
    ras_n = 0; step(3);
    ras_n = 1; step(2);
    cas_n = 1; we_n = 1; step(4);
    expect_ev(tag, 5, cnt_exp);
    cnt_exp = (cnt_exp + 1) % 512;
  endtask

  initial begin
    step(4);
    rst = 0;
    @(posedge clk);
    armed = 1;
    step(1);
    chk("R10 reset evt_valid", evt_valid, 0);
    chk("R10 reset dout_en", dout_en, 0);
    chk("R10 reset viol", viol, 0);

    // R2 early write with OE held low, then R3 read back, R1 aliasing
    early_write(5, 3, 4'hA);
    do_read(5, 3, 4'hA, "R3 read back");
    do_read(21, 19, 4'hA, "R1 aliased read");

    // R4 read-modify-write
    open_read(5, 3, 4'hA, "R4 old data");
    oe_n = 1; din = 4'h6; we_n = 0; step(2);
    cas_n = 1; we_n = 1; step(2);
    ras_n = 1; step(4);
    expect_ev("R4 rmw event", 3, 5);
    do_read(5, 3, 4'h6, "R4 new data");

    // R5 row-only refresh with WE/OE/din wiggling
    addr = 9'd5; we_n = 0; oe_n = 0; din = 4'h9; ras_n = 0; step(3);
    chk("R5 no drive in row-only refresh", dout_en, 0);
    ras_n = 1; we_n = 1; oe_n = 1; step(4);
    expect_ev("R5 row-only event", 4, 5);
    do_read(5, 3, 4'h6, "R5 array unchanged");

    // R6 column-before-row refresh; address and WE ignored
    cbr_cycle("R6 cbr first");
    cbr_cycle("R6 cbr second");
    do_read(5, 3, 4'h6, "R6 array unchanged");

    // R7 hidden refresh keeps read data driven
    early_write(2, 1, 4'hC);
    open_read(2, 1, 4'hC, "R7 read before hidden");
    ras_n = 1; step(2);
    ras_n = 0; step(3);
    chk("R7 held dout_en", dout_en, 1);
    chk("R7 held dout", dout, 4'hC);
    ras_n = 1; step(2);
    chk("R7 still held", dout_en, 1);
    cas_n = 1; oe_n = 1; step(4);
    expect_ev("R7 hidden event", 6, cnt_exp);
    cnt_exp = (cnt_exp + 1) % 512;
    expect_ev("R7 read after hidden", 1, 2);

    // R9 column strobe cycled with no row strobe
    begin
      int v0 = viol_seen;
      cas_n = 0; step(2);
      cas_n = 1; step(4);
      chk("R9 violation pulse", viol_seen, v0 + 1);
      chk("R9 no event", q_code.size(), 0);
    end

    // R11 page mode writes, then page reads
    addr = 9'd9; ras_n = 0; step(2);
    for (int i = 0; i < 3; i++) begin
      addr = 9'(i); din = 4'(i + 1); we_n = 0; cas_n = 0; step(2);
      cas_n = 1; we_n = 1; step(2);
    end
    ras_n = 1; step(4);
    for (int i = 0; i < 3; i++) expect_ev("R11 page event", 2, 9);
    for (int i = 0; i < 3; i++) do_read(9, i, i + 1, "R11 page data");

    // R10 latency of the event strobe
    open_read(9, 1, 2, "R10 lat read");
    cas_n = 1; oe_n = 1;
    step(1); chk("R10 strobe not yet", evt_valid, 0);
    step(1); chk("R10 strobe on", evt_valid, 1);
    step(1); chk("R10 strobe one clock", evt_valid, 0);
    ras_n = 1; step(4);
    expect_ev("R10 lat event", 1, 9);

    // R8 counter wrap
    while (cnt_exp != 511) cbr_cycle("R8 counting");
    cbr_cycle("R8 row 511");
    cbr_cycle("R8 wrap to 0");

    step(4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule